// File: doc/BRIEF.md
# Handle Hash Table Engine

This block owns a table of object handles held in a single-port RAM and serves one command at a time: insert, remove or lookup. Each table slot is eight bytes wide, a handle word followed by a context word, so the RAM holds two 32-bit words per slot. A command carries a 32-bit handle and a channel number. An insert also carries the context word to store. A two-bit mode, sampled with the command, selects how the slot index is hashed and how a slot is judged occupied.

The engine folds the handle into a slot index. It then walks the table one slot at a time from that index and wraps past the last slot back to slot 0. For an insert it stops at the first free slot. For a remove or a lookup it stops at the first occupied slot whose handle matches. It gives up after one full lap. Each command ends in a single response pulse that carries a status code, the slot that was used and the context word involved.

Top module: `handle_hash_engine`

## Requirements
- R1: While reset is asserted and for the 2·2^IDX_W cycles after it is released, the engine zeroes every RAM word. During that time cmdReady and rspValid stay low. Afterwards every lookup misses.
- R2: The hash is the XOR of the handle cut into IDX_W-bit pieces, starting from bit 0, until all 32 bits are used. The last piece may be shorter. The hash selects slot index 0 .. 2^IDX_W-1. Slot s has its handle word at RAM word 2s and its context word at word 2s+1.
- R3: In modes 0 and 1 the channel, shifted left by IDX_W-4 and cut to IDX_W bits, is XORed into the hash. In modes 2 and 3 the channel is ignored.
- R4: In mode 0 a slot is occupied when bit 31 of its context word is 1. In every other mode a slot is occupied when its context word is nonzero.
- R5: An insert (cmdOp 1) probes from the hashed slot and then on to slot+1, wrapping from the last slot to slot 0. It writes the handle and the context into the first free slot it finds. The response has status 0, that slot, and the stored context. In mode 0 the stored context has bit 31 forced to 1. The engine does not check for duplicate handles.
- R6: An insert that comes back to its starting slot without finding a free slot responds with status 2 and context 0, and it writes nothing.
- R7: A remove (cmdOp 2) finds the first occupied slot in probe order whose handle word equals the handle. It writes zero to both words of that slot. It responds with status 0, that slot and the context word it removed. A free slot does not end the search.
- R8: A lookup (cmdOp 0 or 3) probes in the same way and responds with status 0, the slot and its context word. If a full lap finds no match, a remove or a lookup responds with status 1 and context 0.
- R9: cmdReady is high only while idle. A command is taken on a cycle with cmdValid and cmdReady both high. Exactly one single-cycle rspValid pulse follows each command, and cmdReady is high again on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Hash and occupancy rule, sampled with the command |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Engine idle, command taken this cycle if offered |
| cmdOp | input | 2 | 0 lookup, 1 insert, 2 remove, 3 lookup |
| cmdHandle | input | 32 | Object handle |
| cmdChan | input | CHAN_W | Channel number |
| cmdCtx | input | 32 | Context word for insert |
| rspValid | output | 1 | One-cycle response strobe |
| rspStatus | output | 2 | 0 done/found, 1 not found, 2 table full |
| rspSlot | output | IDX_W | Slot touched by the command |
| rspCtx | output | 32 | Stored, removed or found context word, 0 on failure |

## Verification
The assertions watch the handshake on every cycle. They check that ready and response never overlap, that a response is a single pulse followed by ready, and that ready drops once a command is taken. They also check that a failed command always reports context 0 and a legal status code, and that an accepted mode-0 insert reports a context with bit 31 set. Only the bench's scenarios can show the probe order itself. That covers collision chains and lookups that step past a freed slot, wrap-around from the last slot to slot 0, the channel changing the hash per mode, the two occupancy rules reading the same stored words differently, and a table filled to capacity before a slot is freed and reused.

// File: rtl/ht_pkg.sv
package ht_pkg;

  typedef enum logic [1:0] {
    OP_LOOKUP     = 2'd0,
    OP_INSERT     = 2'd1,
    OP_REMOVE     = 2'd2,
    OP_LOOKUP_ALT = 2'd3
  } htOp_e;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_MISS = 2'd1,
    ST_FULL = 2'd2
  } htStatus_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      loadCmd;
    logic      advance;
    logic      latchCtx;
    logic      setRsp;
    htStatus_e rspCode;
    logic      ramEn;
    logic      ramWe;
    logic      addrHdl;
    logic      dataZero;
    logic      clearing;
    logic      clrStep;
  } htStrobe_t;

  // fold handle bits modulo idxW, then optionally mix the channel
  function automatic logic [31:0] htHash(input logic [31:0] handle,
                                         input logic [31:0] chan,
                                         input logic [1:0]  mode,
                                         input int          idxW);
    logic [31:0] acc;
    acc = '0;
    for (int i = 0; i < 32; i++) acc[i % idxW] = acc[i % idxW] ^ handle[i];
    if (mode < 2'd2) acc = acc ^ (chan << (idxW - 4));
    return acc & ((32'd1 << idxW) - 32'd1);
  endfunction

endpackage

// File: rtl/ht_ram.sv
module ht_ram #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/ht_datapath.sv
module ht_datapath
  import ht_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  htStrobe_t         st,
  input  logic [1:0]        mode,
  input  logic [1:0]        cmdOp,
  input  logic [31:0]       cmdHandle,
  input  logic [CHAN_W-1:0] cmdChan,
  input  logic [31:0]       cmdCtx,
  output htOp_e             opR,
  output logic              isValid,
  output logic              handleMatch,
  output logic              lapDone,
  output logic              clrLast,
  output logic [1:0]        rspStatus,
  output logic [IDX_W-1:0]  rspSlot,
  output logic [31:0]       rspCtx
);
  localparam int WORD_W = IDX_W + 1;

  logic [1:0]        modeR;
  logic [31:0]       handleR;
  logic [31:0]       ctxInR;
  logic [31:0]       ctxSeen;
  logic [IDX_W-1:0]  startSlot;
  logic [IDX_W-1:0]  slot;
  logic [IDX_W-1:0]  nextSlot;
  logic [IDX_W-1:0]  hashSlot;
  logic [WORD_W-1:0] clrCnt;
  logic [WORD_W-1:0] ramAddr;
  logic [31:0]       ramWdata;
  logic [31:0]       ramRdata;

  assign hashSlot = IDX_W'(htHash(cmdHandle, 32'(cmdChan), mode, IDX_W));
  assign nextSlot = slot + 1'b1;   // wraps from last slot to 0
  assign lapDone  = (nextSlot == startSlot);
  assign clrLast  = &clrCnt;

  // handle word at even address, context word at odd address
  assign ramAddr  = st.clearing ? clrCnt : {slot, ~st.addrHdl};
  assign ramWdata = (st.clearing || st.dataZero) ? 32'd0 :
                    (st.addrHdl ? handleR : ctxInR);

  assign isValid     = (modeR == 2'd0) ? ramRdata[31] : (ramRdata != 32'd0);
  assign handleMatch = (ramRdata == handleR);

  ht_ram #(.ADDR_W(WORD_W), .DATA_W(32)) uRam (
    .clk  (clk),
    .en   (st.ramEn),
    .we   (st.ramWe),
    .addr (ramAddr),
    .wdata(ramWdata),
    .rdata(ramRdata)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR       <= OP_LOOKUP;
      modeR     <= '0;
      handleR   <= '0;
      ctxInR    <= '0;
      ctxSeen   <= '0;
      startSlot <= '0;
      slot      <= '0;
      clrCnt    <= '0;
      rspStatus <= '0;
      rspSlot   <= '0;
      rspCtx    <= '0;
    end else begin
      if (st.loadCmd) begin
        opR       <= htOp_e'(cmdOp);
        modeR     <= mode;
        handleR   <= cmdHandle;
        ctxInR    <= (mode == 2'd0) ? (cmdCtx | 32'h8000_0000) : cmdCtx;
        startSlot <= hashSlot;
        slot      <= hashSlot;
      end
      if (st.advance)  slot    <= nextSlot;
      if (st.latchCtx) ctxSeen <= ramRdata;
      if (st.clrStep)  clrCnt  <= clrCnt + 1'b1;
      if (st.setRsp) begin
        rspStatus <= st.rspCode;
        rspSlot   <= slot;
        if (st.rspCode != ST_OK)   rspCtx <= 32'd0;
        else if (opR == OP_INSERT) rspCtx <= ctxInR;
        else                       rspCtx <= ctxSeen;
      end
    end
  end
endmodule

// File: rtl/ht_control.sv
module ht_control
  import ht_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  output logic      cmdReady,
  output logic      rspValid,
  input  htOp_e     opR,
  input  logic      isValid,
  input  logic      handleMatch,
  input  logic      lapDone,
  input  logic      clrLast,
  output htStrobe_t st
);
  typedef enum logic [2:0] {
    S_CLR, S_IDLE, S_RDCTX, S_CHKCTX, S_CHKHDL, S_WRHDL, S_WRCTX, S_RESP
  } htState_e;

  htState_e state, stateNxt;
  logic isInsert, isRemove;

  assign isInsert = (opR == OP_INSERT);
  assign isRemove = (opR == OP_REMOVE);
  assign cmdReady = (state == S_IDLE);
  assign rspValid = (state == S_RESP);

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_CLR;
    else       state <= stateNxt;
  end

  always_comb begin
    st         = '0;
    st.rspCode = ST_OK;
    stateNxt   = state;
    unique case (state)
      S_CLR: begin
        st.clearing = 1'b1;
        st.ramEn    = 1'b1;
        st.ramWe    = 1'b1;
        st.clrStep  = 1'b1;
        if (clrLast) stateNxt = S_IDLE;
      end
      S_IDLE: begin
        if (cmdValid) begin
          st.loadCmd = 1'b1;
          stateNxt   = S_RDCTX;
        end
      end
      S_RDCTX: begin
        st.ramEn = 1'b1;            // read context word
        stateNxt = S_CHKCTX;
      end
      S_CHKCTX: begin
        st.latchCtx = 1'b1;
        st.ramEn    = 1'b1;         // prefetch handle word of same slot
        st.addrHdl  = 1'b1;
        if (isInsert ? !isValid : isValid) begin
          stateNxt = isInsert ? S_WRHDL : S_CHKHDL;
        end else if (lapDone) begin
          st.setRsp  = 1'b1;
          st.rspCode = isInsert ? ST_FULL : ST_MISS;
          stateNxt   = S_RESP;
        end else begin
          st.advance = 1'b1;
          stateNxt   = S_RDCTX;
        end
      end
      S_CHKHDL: begin
        if (handleMatch) begin
          if (isRemove) stateNxt = S_WRHDL;
          else begin
            st.setRsp = 1'b1;
            stateNxt  = S_RESP;
          end
        end else if (lapDone) begin
          st.setRsp  = 1'b1;
          st.rspCode = ST_MISS;
          stateNxt   = S_RESP;
        end else begin
          st.advance = 1'b1;
          stateNxt   = S_RDCTX;
        end
      end
      S_WRHDL: begin
        st.ramEn    = 1'b1;
        st.ramWe    = 1'b1;
        st.addrHdl  = 1'b1;
        st.dataZero = isRemove;
        stateNxt    = S_WRCTX;
      end
      S_WRCTX: begin
        st.ramEn    = 1'b1;
        st.ramWe    = 1'b1;
        st.dataZero = isRemove;
        st.setRsp   = 1'b1;
        stateNxt    = S_RESP;
      end
      S_RESP: stateNxt = S_IDLE;
      default: stateNxt = S_CLR;
    endcase
  end
endmodule

// File: rtl/handle_hash_engine.sv
module handle_hash_engine
  import ht_pkg::*;
#(
  parameter int IDX_W  = 6,   // at least 4
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [31:0]       cmdHandle,
  input  logic [CHAN_W-1:0] cmdChan,
  input  logic [31:0]       cmdCtx,
  output logic              rspValid,
  output logic [1:0]        rspStatus,
  output logic [IDX_W-1:0]  rspSlot,
  output logic [31:0]       rspCtx
);
  htStrobe_t st;
  htOp_e     opR;
  logic      isValid, handleMatch, lapDone, clrLast;

  ht_control uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdReady   (cmdReady),
    .rspValid   (rspValid),
    .opR        (opR),
    .isValid    (isValid),
    .handleMatch(handleMatch),
    .lapDone    (lapDone),
    .clrLast    (clrLast),
    .st         (st)
  );

  ht_datapath #(.IDX_W(IDX_W), .CHAN_W(CHAN_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .mode       (mode),
    .cmdOp      (cmdOp),
    .cmdHandle  (cmdHandle),
    .cmdChan    (cmdChan),
    .cmdCtx     (cmdCtx),
    .opR        (opR),
    .isValid    (isValid),
    .handleMatch(handleMatch),
    .lapDone    (lapDone),
    .clrLast    (clrLast),
    .rspStatus  (rspStatus),
    .rspSlot    (rspSlot),
    .rspCtx     (rspCtx)
  );
endmodule

// File: rtl/ht_checker.sv
module ht_checker (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  mode,
  input logic        cmdValid,
  input logic        cmdReady,
  input logic [1:0]  cmdOp,
  input logic        rspValid,
  input logic [1:0]  rspStatus,
  input logic [31:0] rspCtx
);
  logic [1:0] pendOp;
  logic [1:0] pendMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendOp   <= 2'd0;
      pendMode <= 2'd0;
    end else if (cmdValid && cmdReady) begin
      pendOp   <= cmdOp;
      pendMode <= mode;
    end
  end

  // R9
  ready_rsp_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdReady && rspValid));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && cmdReady));

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  // R6
  status_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspStatus != 2'd3));

  // R8
  miss_ctx_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus != 2'd0) |-> (rspCtx == 32'd0));

  // R5
  oldest_valid_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus == 2'd0 && pendOp == 2'd1 && pendMode == 2'd0)
      |-> rspCtx[31]);
endmodule

bind handle_hash_engine ht_checker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .mode     (mode),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .cmdOp    (cmdOp),
  .rspValid (rspValid),
  .rspStatus(rspStatus),
  .rspCtx   (rspCtx)
);

// File: tb/tb_handle_hash_engine.sv
module tb_handle_hash_engine;
  localparam int IDX_W  = 6;
  localparam int CHAN_W = 5;
  localparam int N      = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        mode = '0;
  logic              cmdValid = 1'b0;
  logic              cmdReady;
  logic [1:0]        cmdOp = '0;
  logic [31:0]       cmdHandle = '0;
  logic [CHAN_W-1:0] cmdChan = '0;
  logic [31:0]       cmdCtx = '0;
  logic              rspValid;
  logic [1:0]        rspStatus;
  logic [IDX_W-1:0]  rspSlot;
  logic [31:0]       rspCtx;

  always #2.5 clk = ~clk;   // 200 MHz

  handle_hash_engine #(.IDX_W(IDX_W), .CHAN_W(CHAN_W)) dut (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference table
  logic [31:0] mH [N];
  logic [31:0] mC [N];

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  md;
    logic [31:0] h;
    logic [4:0]  ch;
    logic [31:0] ctx;
    logic [1:0]  expSt;
    logic [7:0]  expSlot;   // 8'hFF: slot not checked literally
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'd2, 32'h0000_0001, 5'd0, 32'h11, 2'd0, 8'd1},
    '{2'd1, 2'd2, 32'h0000_0040, 5'd0, 32'h22, 2'd0, 8'd2},
    '{2'd0, 2'd2, 32'h0000_0040, 5'd0, 32'h0,  2'd0, 8'd2},
    '{2'd2, 2'd2, 32'h0000_0001, 5'd0, 32'h0,  2'd0, 8'd1},
    '{2'd0, 2'd2, 32'h0000_0040, 5'd0, 32'h0,  2'd0, 8'd2},
    '{2'd3, 2'd2, 32'h0000_0001, 5'd0, 32'h0,  2'd1, 8'hFF},
    '{2'd1, 2'd2, 32'h0000_003F, 5'd0, 32'h33, 2'd0, 8'd63},
    '{2'd1, 2'd2, 32'h0000_0FC0, 5'd0, 32'h44, 2'd0, 8'd0},
    '{2'd0, 2'd2, 32'h0000_0FC0, 5'd0, 32'h0,  2'd0, 8'd0},
    '{2'd1, 2'd0, 32'h0000_0000, 5'd1, 32'h55, 2'd0, 8'd4},
    '{2'd0, 2'd3, 32'h0000_0000, 5'd1, 32'h0,  2'd0, 8'd4},
    '{2'd0, 2'd0, 32'h0000_0040, 5'd0, 32'h0,  2'd1, 8'hFF},
    '{2'd0, 2'd1, 32'h0000_0040, 5'd0, 32'h0,  2'd0, 8'd2},
    '{2'd1, 2'd1, 32'h1234_5678, 5'd3, 32'h66, 2'd0, 8'd55}
  };
  localparam string TAGS [NV] = '{
    "R2", "R5", "R8", "R7", "R7", "R8", "R2",
    "R5", "R8", "R3", "R3", "R4", "R4", "R3"
  };

  function automatic int bHash(input logic [31:0] h, input int ch, input logic [1:0] md);
    logic [31:0] acc, tmp, mask;
    mask = (32'd1 << IDX_W) - 1;
    acc = 0;
    tmp = h;
    for (int left = 32; left > 0; left -= IDX_W) begin
      acc ^= tmp & mask;
      tmp = tmp >> IDX_W;
    end
    if (md < 2) acc ^= (32'(ch) << (IDX_W - 4)) & mask;
    return int'(acc);
  endfunction

  function automatic bit occupied(input int s, input logic [1:0] md);
    return (md == 2'd0) ? mC[s][31] : (mC[s] != 0);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < N; i++) begin
      mH[i] = 0;
      mC[i] = 0;
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cmdValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelClear();
    @(negedge clk);
    check(!cmdReady && !rspValid, "R1", "busy after reset",
          {cmdReady, rspValid}, 0);
    begin
      int waitCnt = 1;
      while (!cmdReady && waitCnt < 4 * N) begin
        @(negedge clk);
        waitCnt++;
      end
      check(waitCnt >= 2 * N - 1 && waitCnt <= 2 * N + 2, "R1", "clear length",
            waitCnt, 2 * N);
    end
  endtask

  // issue one command, compare against reference model, update model
  task automatic doCmd(input logic [1:0] op, input logic [1:0] md,
                       input logic [31:0] h, input int ch, input logic [31:0] ctx,
                       input string req, output logic [1:0] gotSt,
                       output int gotSlot);
    int start, hit;
    logic [1:0]  eSt;
    logic [31:0] eCtx;
    start = bHash(h, ch, md);
    hit = -1;
    for (int k = 0; k < N; k++) begin
      int s;
      s = (start + k) % N;
      if (hit < 0) begin
        if (op == 2'd1) begin
          if (!occupied(s, md)) hit = s;
        end else if (occupied(s, md) && mH[s] == h) hit = s;
      end
    end
    eCtx = 0;
    if (hit < 0) eSt = (op == 2'd1) ? 2'd2 : 2'd1;
    else begin
      eSt = 2'd0;
      if (op == 2'd1) begin
        eCtx = (md == 2'd0) ? (ctx | 32'h8000_0000) : ctx;
        mH[hit] = h;
        mC[hit] = eCtx;
      end else begin
        eCtx = mC[hit];
        if (op == 2'd2) begin
          mH[hit] = 0;
          mC[hit] = 0;
        end
      end
    end

    while (!cmdReady) @(negedge clk);
    cmdOp = op; mode = md; cmdHandle = h; cmdChan = CHAN_W'(ch); cmdCtx = ctx;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    while (!rspValid) @(negedge clk);
    gotSt = rspStatus;
    gotSlot = int'(rspSlot);
    if (eSt == 2'd0)
      check(rspStatus == eSt && rspCtx == eCtx && int'(rspSlot) == hit, req,
            "status/ctx/slot", {rspStatus, rspCtx, 8'(rspSlot)},
            {eSt, eCtx, 8'(hit)});
    else
      check(rspStatus == eSt && rspCtx == 0, req, "status/ctx",
            {rspStatus, rspCtx}, {eSt, 32'd0});
    @(negedge clk);
    check(!rspValid && cmdReady, "R9", "single pulse then ready",
          {rspValid, cmdReady}, 2'b01);
  endtask

  initial begin
    logic [1:0] st;
    int sl;
    doReset();
    // empty table after clear
    doCmd(2'd0, 2'd2, 32'h0, 0, 0, "R1", st, sl);
    check(st == 2'd1, "R1", "empty table lookup", st, 1);

    for (int v = 0; v < NV; v++) begin
      doCmd(VECS[v].op, VECS[v].md, VECS[v].h, int'(VECS[v].ch), VECS[v].ctx,
            TAGS[v], st, sl);
      check(st == VECS[v].expSt, TAGS[v], "vector status", st, VECS[v].expSt);
      if (VECS[v].expSlot != 8'hFF)
        check(sl == int'(VECS[v].expSlot), TAGS[v], "vector slot", sl,
              VECS[v].expSlot);
    end

    // full table
    doReset();
    for (int i = 0; i < N; i++)
      doCmd(2'd1, 2'd2, 32'h0001_0000 + 32'(i * 37), 0, 32'(i + 1), "R5", st, sl);
    doCmd(2'd1, 2'd2, 32'h0000_0999, 0, 32'h77, "R6", st, sl);
    check(st == 2'd2, "R6", "full status", st, 2);
    doCmd(2'd0, 2'd2, 32'h0000_0999, 0, 0, "R6", st, sl);
    check(st == 2'd1, "R6", "nothing written when full", st, 1);
    // free one slot (entry i=5) and reuse it
    doCmd(2'd2, 2'd2, 32'h0001_0000 + 32'(5 * 37), 0, 0, "R7", st, sl);
    begin
      int freed;
      freed = sl;
      doCmd(2'd1, 2'd2, 32'h0000_0999, 0, 32'h77, "R5", st, sl);
      check(st == 2'd0 && sl == freed, "R5", "reuse freed slot", sl, freed);
    end
    doCmd(2'd0, 2'd2, 32'h0001_0000 + 32'(5 * 37), 0, 0, "R7", st, sl);
    check(st == 2'd1, "R7", "removed handle gone", st, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule